// File: doc/BRIEF.md
# Clock-Generator Configuration Serial Slave

This block is a two-wire serial slave that holds the configuration bytes of a clock generator. A fast system clock oversamples SCL and SDA. The block finds START and STOP conditions, matches its own 7-bit device address and acknowledges each byte it accepts. SDA is open-drain: the block only ever pulls the line low, through `sda_oe_o`.

A write transfer carries a command byte and a byte-count byte, then up to six data bytes. The slave acknowledges the command and count bytes and discards their values. Data bytes fill the registers from index 0 upward. A read transfer returns a count byte and then all six registers in index order.

The register contents drive the control pins of the clock generator:
- the frequency code, taken either from the strap pins or from software;
- spread enable and spread direction;
- a tristate request;
- four bytes of per-output enables.

All control pins are plain levels. No data stream leaves the block, so it has no valid/ready handshake and no back-pressure.

Top module: `cfgbus_slave`

## Requirements
- R1: The slave answers only to device address 0x69: the write address byte is 0xD2 and the read address byte is 0xD3. For any other address byte it never pulls SDA low, and the registers do not change.
- R2: In a write, the slave acknowledges the first two bytes after the address (command and count), but their values are not stored anywhere.
- R3: In a write, the data bytes load registers 0, 1, 2 and onward in arrival order, and each accepted byte is acknowledged on its own.
- R4: A STOP after any complete data byte ends the write. Registers already loaded keep their new values, and the rest keep their old values.
- R5: A seventh or later data byte in one write is not acknowledged and changes no register.
- R6: A read returns the count byte 0x06 first, then registers 0 to 5 in order. The next byte follows only while the master acknowledges; a master NACK ends the read.
- R7: After reset, registers 1, 2, 3 and 5 are 0xFF, so every output enable is set. Register 0 is 0x00, so spread, down-spread and tristate are all off and the frequency comes from the straps.
- R8: Register 0 layout:
  - bit 7: down spread (1) or center spread (0);
  - bit 1: spread enable;
  - bit 0: tristate;
  - bit 3: frequency source, 1 for software and 0 for the straps;
  - software frequency code = {bit 2, bits 6:4}.
- R9: The straps are latched once after reset. Register 4 reads as the inverted latched straps: bit 5 is the inverted 24/48 select, bit 3 is the inverted FS1, bit 1 is the inverted FS3, and every other bit reads 1. Writes to register 4 are acknowledged but have no effect, and later changes on the strap pins have no effect.
- R10: A repeated START resets the byte pointer, and the slave waits for a new address byte.
- R11: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, pull SDA low |
| strap_fs_i | input | 4 | Frequency-select strap pins |
| strap_sel_i | input | 1 | 24/48 select strap pin |
| freq_code_o | output | 4 | Frequency code in effect |
| spread_en_o | output | 1 | Spread modulation enable |
| spread_down_o | output | 1 | 1 = down spread, 0 = center spread |
| tristate_o | output | 1 | Tristate all clock outputs |
| cpu_en_o | output | 8 | Enable byte from register 1 |
| pci_en_o | output | 8 | Enable byte from register 2 |
| mem_en_o | output | 8 | Enable byte from register 3 |
| per_en_o | output | 8 | Enable byte from register 5 |

## Verification
The assertions check on every cycle:
- `sda_oe_o` moves only while SCL is low;
- an idle slave never pulls SDA;
- a STOP returns the engine to idle;
- register writes target in-range indices and occur only during a transfer;
- the enable bytes stay stable in cycles without a write.

Only the bench scenarios can show the rest:
- the byte-level protocol: which bytes are acknowledged, that the header bytes are dropped, and that a read returns the count followed by the registers in order;
- the decode of register 0 and the inverted strap byte;
- the pointer restart after a repeated START.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_t;

  localparam int CTRL_IDX  = 0;
  localparam int STRAP_IDX = 4;
endpackage

// File: rtl/cfgbus_sampler.sv
module cfgbus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
      assign scl_s = scl_pipe[SYNC_STAGES-1];
      assign sda_s = sda_pipe[SYNC_STAGES-1];
    end else begin : g_single
      logic scl_r, sda_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_r <= 1'b1;
          sda_r <= 1'b1;
        end else begin
          scl_r <= scl_i;
          sda_r <= sda_i;
        end
      end
      assign scl_s = scl_r;
      assign sda_s = sda_r;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgbus_engine.sv
module cfgbus_engine
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 6,
  localparam int IW = $clog2(NUM_REGS + 3),
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe,
  output logic          idle
);
  localparam logic [IW-1:0] HDR_BYTES = IW'(2);
  localparam logic [IW-1:0] END_IDX   = IW'(NUM_REGS + 2);

  bus_state_t    state;
  logic [2:0]    bit_cnt;
  logic          byte_full, rw_q, mack_q;
  logic [7:0]    rx_sh, tx_sh;
  logic [IW-1:0] idx;

  assign wr_en   = (state == ST_RX) && scl_fall && byte_full &&
                   (idx >= HDR_BYTES) && (idx < END_IDX);
  assign wr_addr = AW'(idx - HDR_BYTES);
  assign wr_data = rx_sh;
  assign rd_addr = idx;
  assign idle    = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      idx       <= '0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      state     <= ST_ADDR;
      bit_cnt   <= '0;
      byte_full <= 1'b0;
      idx       <= '0;
      sda_oe    <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      byte_full <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) byte_full <= 1'b1;
          end else if (scl_fall && byte_full) begin
            byte_full <= 1'b0;
            if (state == ST_ADDR) begin
              if (rx_sh[7:1] == DEV_ADDR) begin
                rw_q   <= rx_sh[0];
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (idx < END_IDX) begin
              sda_oe <= 1'b1;
              idx    <= idx + IW'(1);
              state  <= ST_RX_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              idx    <= idx + IW'(1);
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_TX_ACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              sda_oe  <= ~tx_sh[6];
              bit_cnt <= bit_cnt + 3'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              idx    <= idx + IW'(1);
              state  <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgbus_regfile.sv
module cfgbus_regfile
  import cfgbus_pkg::*;
#(
  parameter int NUM_REGS = 6,
  localparam int IW = $clog2(NUM_REGS + 3),
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            strap_fs_i,
  input  logic                  strap_sel_i,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [IW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic [3:0]            strap_fs_q,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  logic       strap_done;
  logic       strap_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_done  <= 1'b0;
      strap_fs_q  <= '0;
      strap_sel_q <= 1'b0;
    end else if (!strap_done) begin
      strap_done  <= 1'b1;
      strap_fs_q  <= strap_fs_i;
      strap_sel_q <= strap_sel_i;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      if (g == STRAP_IDX) begin : g_strap
        assign regs_flat[g*8 +: 8] = {2'b11, ~strap_sel_q, 1'b1,
                                      ~strap_fs_q[1], 1'b1, ~strap_fs_q[3], 1'b1};
      end else begin : g_rw
        localparam logic [7:0] RST_VAL = (g == CTRL_IDX) ? 8'h00 : 8'hFF;
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RST_VAL;
          else if (wr_en && wr_addr == AW'(g)) q <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = q;
      end
    end
  endgenerate

  always_comb begin
    rd_data = 8'hFF;
    if (rd_addr == '0) rd_data = 8'(NUM_REGS);
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == IW'(i + 1)) rd_data = regs_flat[i*8 +: 8];
    end
  end
endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NUM_REGS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [3:0] strap_fs_i,
  input  logic       strap_sel_i,
  output logic [3:0] freq_code_o,
  output logic       spread_en_o,
  output logic       spread_down_o,
  output logic       tristate_o,
  output logic [7:0] cpu_en_o,
  output logic [7:0] pci_en_o,
  output logic [7:0] mem_en_o,
  output logic [7:0] per_en_o
);
  localparam int IW = $clog2(NUM_REGS + 3);
  localparam int AW = $clog2(NUM_REGS);

  logic                  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]            rd_data, wr_data, ctrl;
  logic [IW-1:0]         rd_addr;
  logic                  wr_en, fsm_idle;
  logic [AW-1:0]         wr_addr;
  logic [3:0]            strap_fs_q;
  logic [NUM_REGS*8-1:0] regs_flat;

  cfgbus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgbus_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_oe(sda_oe_o), .idle(fsm_idle)
  );

  cfgbus_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_fs_i(strap_fs_i), .strap_sel_i(strap_sel_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .strap_fs_q(strap_fs_q), .regs_flat(regs_flat)
  );

  assign ctrl = regs_flat[CTRL_IDX*8 +: 8];

  always_comb begin
    freq_code_o   = ctrl[3] ? {ctrl[2], ctrl[6:4]} : strap_fs_q;
    spread_en_o   = ctrl[1];
    spread_down_o = ctrl[7];
    tristate_o    = ctrl[0];
    cpu_en_o      = regs_flat[1*8 +: 8];
    pci_en_o      = regs_flat[2*8 +: 8];
    mem_en_o      = regs_flat[3*8 +: 8];
    per_en_o      = regs_flat[5*8 +: 8];
  end

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/cfgbus_slave_chk.sv
module cfgbus_slave_chk #(
  parameter int NUM_REGS = 6,
  localparam int AW = $clog2(NUM_REGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          fsm_idle,
  input logic          stop_det,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    cpu_en_o,
  input logic [7:0]    pci_en_o,
  input logic [7:0]    mem_en_o,
  input logic [7:0]    per_en_o
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i); // R11

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_idle |-> !sda_oe_o); // R1

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> fsm_idle); // R4

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < NUM_REGS)); // R5

  AST_WR_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !fsm_idle); // R3

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable({cpu_en_o, pci_en_o, mem_en_o, per_en_o})); // R4
endmodule

bind cfgbus_slave cfgbus_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .fsm_idle(fsm_idle), .stop_det(stop_det), .wr_en(wr_en), .wr_addr(wr_addr),
  .cpu_en_o(cpu_en_o), .pci_en_o(pci_en_o), .mem_en_o(mem_en_o), .per_en_o(per_en_o)
);

// File: tb/cfgbus_slave_tb.sv
module cfgbus_slave_tb;
  localparam int H = 12;
  localparam int WD_LIMIT = 190000;
  localparam logic [7:0] AW_BYTE = 8'hD2;
  localparam logic [7:0] AR_BYTE = 8'hD3;
  localparam logic [7:0] REG4_EXP = 8'hD5; // straps fs=1010 sel=1, inverted

  // {data byte count, bytes 0..5 (byte 0 in the top bits)}
  localparam logic [51:0] VEC [4] = '{
    {4'd6, 48'h00A55A3C77C3},
    {4'd2, 48'h12F000000000},
    {4'd0, 48'h000000000000},
    {4'd4, 48'h810F11220000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [3:0] strap_fs = 4'b1010;
  logic strap_sel = 1'b1;
  logic [3:0] freq_code;
  logic spread_en, spread_down, tristate;
  logic [7:0] cpu_en, pci_en, mem_en, per_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] model [6];

  always #2 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  cfgbus_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_fs_i(strap_fs), .strap_sel_i(strap_sel), .freq_code_o(freq_code),
    .spread_en_o(spread_en), .spread_down_o(spread_down), .tristate_o(tristate),
    .cpu_en_o(cpu_en), .pci_en_o(pci_en), .mem_en_o(mem_en), .per_en_o(per_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_low = 1'b0; wt(H);
    scl = 1'b1; wt(H);
    m_low = 1'b1; wt(H);
    scl = 1'b0; wt(4);
  endtask

  task automatic bus_stop;
    m_low = 1'b1; wt(H);
    scl = 1'b1; wt(H);
    m_low = 1'b0; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wt(H);
      scl = 1'b1; wt(H);
      scl = 1'b0; wt(4);
    end
    m_low = 1'b0; wt(H);
    scl = 1'b1; wt(H/2);
    acked = ~sda_line; wt(H/2);
    scl = 1'b0; wt(4);
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_low = 1'b0; wt(H);
      scl = 1'b1; wt(H/2);
      b[i] = sda_line; wt(H/2);
      scl = 1'b0; wt(4);
    end
    m_low = ack_it; wt(H);
    scl = 1'b1; wt(H);
    scl = 1'b0; wt(4);
    m_low = 1'b0;
  endtask

  // ackv bit 0 address, 1 command, 2 count, 3+i data i
  task automatic write_tx(input int n, input logic [63:0] d, output logic [10:0] ackv);
    logic a;
    ackv = '0;
    bus_start;
    send_byte(AW_BYTE, a); ackv[0] = a;
    send_byte(8'hAB, a);   ackv[1] = a;
    send_byte(8'hCD, a);   ackv[2] = a;
    for (int i = 0; i < n; i++) begin
      send_byte(d[63-8*i -: 8], a);
      ackv[3+i] = a;
    end
    bus_stop;
  endtask

  task automatic read_tx(output logic [7:0] cnt, output logic [47:0] rb);
    logic a;
    logic [7:0] b;
    bus_start;
    send_byte(AR_BYTE, a);
    chk("R6 read address ack", {31'd0, a}, 32'd1);
    recv_byte(1'b1, cnt);
    for (int i = 0; i < 6; i++) begin
      recv_byte(i < 5, b);
      rb[47-8*i -: 8] = b;
    end
    bus_stop;
  endtask

  task automatic check_all(input string req);
    logic [7:0] cnt;
    logic [47:0] rb;
    read_tx(cnt, rb);
    chk({req, " R6 count"}, {24'd0, cnt}, 32'h6);
    for (int i = 0; i < 6; i++)
      chk({req, " readback"}, {24'd0, rb[47-8*i -: 8]}, {24'd0, model[i]});
    chk({req, " cpu_en"}, {24'd0, cpu_en}, {24'd0, model[1]});
    chk({req, " pci_en"}, {24'd0, pci_en}, {24'd0, model[2]});
    chk({req, " mem_en"}, {24'd0, mem_en}, {24'd0, model[3]});
    chk({req, " per_en"}, {24'd0, per_en}, {24'd0, model[5]});
  endtask

  task automatic apply_model(input int n, input logic [63:0] d);
    for (int i = 0; i < n && i < 6; i++)
      if (i != 4) model[i] = d[63-8*i -: 8];
  endtask

  initial begin
    logic [10:0] ackv;
    logic a;
    logic [7:0] b;
    model = '{8'h00, 8'hFF, 8'hFF, 8'hFF, REG4_EXP, 8'hFF};
    wt(5);
    rst_n = 1'b1;
    wt(10);

    // R7 reset state, R8 strap source
    chk("R7 cpu_en", {24'd0, cpu_en}, 32'hFF);
    chk("R7 pci_en", {24'd0, pci_en}, 32'hFF);
    chk("R7 mem_en", {24'd0, mem_en}, 32'hFF);
    chk("R7 per_en", {24'd0, per_en}, 32'hFF);
    chk("R7 spread/down/tri", {29'd0, spread_en, spread_down, tristate}, 32'd0);
    chk("R8 strap freq", {28'd0, freq_code}, 32'hA);
    chk("R11 idle release", {31'd0, sda_oe}, 32'd0);

    // R9 straps latched: pin changes ignored
    strap_fs = 4'b0101; strap_sel = 1'b0;
    wt(20);
    chk("R9 strap latched", {28'd0, freq_code}, 32'hA);
    check_all("R7 R9 initial");

    // R1 foreign addresses
    bus_start; send_byte(8'hA4, a); bus_stop;
    chk("R1 foreign addr nack", {31'd0, a}, 32'd0);
    bus_start; send_byte(8'hD0, a); send_byte(8'h00, b[0]); bus_stop;
    chk("R1 near addr nack", {31'd0, a}, 32'd0);
    chk("R1 no drive after", {31'd0, b[0]}, 32'd0);

    // Table walk: R2 R3 R4
    foreach (VEC[k]) begin
      int n;
      logic [63:0] d;
      n = int'(VEC[k][51:48]);
      d = {VEC[k][47:0], 16'h0};
      write_tx(n, d, ackv);
      chk("R1 addr ack", {31'd0, ackv[0]}, 32'd1);
      chk("R2 header acks", {30'd0, ackv[2:1]}, 32'd3);
      for (int i = 0; i < n; i++)
        chk("R3 data ack", {31'd0, ackv[3+i]}, 32'd1);
      apply_model(n, d);
      check_all("R3 R4 table");
    end

    // R8 software frequency code: reg0=0x5C -> code 1101, spread off
    write_tx(1, {8'h5C, 56'h0}, ackv);
    chk("R8 soft code", {28'd0, freq_code}, 32'hD);
    chk("R8 flags off", {29'd0, spread_en, spread_down, tristate}, 32'd0);
    // reg0=0x83 -> down spread, spread on, tristate on, strap source
    write_tx(1, {8'h83, 56'h0}, ackv);
    chk("R8 strap again", {28'd0, freq_code}, 32'hA);
    chk("R8 flags on", {29'd0, spread_en, spread_down, tristate}, 32'h7);
    model[0] = 8'h83;

    // R5 seventh data byte, R9 reg4 write ignored
    write_tx(7, 64'h1122334400669900, ackv);
    chk("R9 reg4 write acked", {31'd0, ackv[7]}, 32'd1);
    chk("R5 extra byte nack", {31'd0, ackv[9]}, 32'd0);
    apply_model(7, 64'h1122334400669900);
    check_all("R5 R9 overflow");

    // R10 repeated start into read
    bus_start; send_byte(AW_BYTE, a); send_byte(8'hAB, a);
    bus_start; send_byte(AR_BYTE, a);
    chk("R10 read addr after rs", {31'd0, a}, 32'd1);
    recv_byte(1'b1, b);
    chk("R10 count after rs", {24'd0, b}, 32'h6);
    recv_byte(1'b0, b);
    chk("R10 reg0 after rs", {24'd0, b}, {24'd0, model[0]});
    bus_stop;

    // R10 repeated start restarts the write pointer
    bus_start; send_byte(AW_BYTE, a); send_byte(8'h01, a); send_byte(8'h02, a);
    send_byte(8'h3C, a);
    bus_start; send_byte(AW_BYTE, a); send_byte(8'h01, a); send_byte(8'h02, a);
    send_byte(8'h7E, a);
    bus_stop;
    model[0] = 8'h7E;
    check_all("R10 pointer restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule